// File: doc/BRIEF.md
# Compute-Unit Completion Status Collector

This block turns completion signals from a bank of compute units into a bitmask that the control processor can read. Each compute unit drives one done line. When the collector sees a rising edge on a line, it sets the matching bit in the status register, provided that completion capture is enabled and the unit's index is below the configured unit count. The processor reads the bitmask, and the read clears it. A processor interrupt stays asserted while any bit remains set.

A second register carries status from the processor to the host. The processor writes a word into it and the host reads it, and the host's read clears it. If host interrupts are enabled, each processor write produces a one-cycle interrupt pulse toward the host.

Top module: `cu_status_collector`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cuStatus`, `hostStatus`, `hostIrq` and `cpuIrq` are all zero.
- R2: With `isrEnable` high, a rising edge on `cuDone[i]` with i < `numCus` sets bit i of `cuStatus` at the next clock edge. The new value is visible in the cycle after the edge was sampled.
- R3: A done line that stays high sets its bit only once. If the processor clears the bit while the line is still high, the bit stays clear until the line falls and rises again.
- R4: Rising edges on `cuDone[i]` with i >= `numCus` never set a bit. A `numCus` of 0 monitors no unit.
- R5: While `isrEnable` is low, no bit of `cuStatus` is set. An edge seen during that time is not remembered.
- R6: When `cpuRd` is high in a cycle, `cuStatus` reads as zero from the next cycle on. The exception is a bit whose unit shows a qualifying rising edge in that same cycle: that bit is set after the clear.
- R7: `cpuIrq` is high exactly when any bit of `cuStatus` is set.
- R8: `hostWr` loads `hostWrData` into `hostStatus` at the next edge. `hostRd` clears `hostStatus` at the next edge. If both are high in the same cycle, the write wins.
- R9: `hostIrq` is high for exactly the one cycle after each cycle in which `hostWr` and `hostIrqEnable` are both high, and it is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cuDone | input | MAX_CUS | Per-unit done lines |
| isrEnable | input | 1 | Enables capture of completions |
| numCus | input | $clog2(MAX_CUS+1) | Number of monitored units |
| cpuRd | input | 1 | Processor read strobe for the completion bitmask (clear-on-read) |
| cuStatus | output | MAX_CUS | Completion bitmask |
| cpuIrq | output | 1 | Processor interrupt, high while any completion is pending |
| hostIrqEnable | input | 1 | Enables the host interrupt pulse |
| hostWr | input | 1 | Processor write strobe for the host status word |
| hostWrData | input | HOST_W | Data for the host status word |
| hostRd | input | 1 | Host read strobe (clear-on-read) |
| hostStatus | output | HOST_W | Host status word |
| hostIrq | output | 1 | One-cycle host interrupt pulse |

## Verification
A stuck or wrongly cleared bit in the completion bitmask appears on `cuStatus` and `cpuIrq` in the very next cycle. A behavioural model compares every output on every clock, so the bench catches the error in the cycle where it first appears. A wrong edge-detect history is harder to see. It only shows up when a line is held high across a read, or when a unit rises while capture is disabled, so the bench drives both cases on purpose. A faulty host path shows one cycle after the write or read that exposes it, as a wrong word or as a pulse that is missing or too long.

// File: rtl/cusc_pkg.sv
package cusc_pkg;
  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic clearCu;    // processor read of the completion mask
    logic loadHost;   // processor write of the host word
    logic clearHost;  // host read of the host word
  } ctrlStrobes_t;
endpackage

// File: rtl/cusc_ctrl.sv
module cusc_ctrl
  import cusc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuRd,
  input  logic         hostWr,
  input  logic         hostRd,
  input  logic         hostIrqEnable,
  output ctrlStrobes_t strb,
  output logic         hostIrq
);
  always_comb begin
    strb.clearCu   = cpuRd;
    strb.loadHost  = hostWr;
    // a write in the same cycle takes precedence over the host's clear
    strb.clearHost = hostRd && !hostWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostIrq <= 1'b0;
    else       hostIrq <= hostWr && hostIrqEnable;
  end

  // R9: every pulse is caused by an enabled write one cycle earlier
  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(hostWr && hostIrqEnable));
endmodule

// File: rtl/cusc_datapath.sv
module cusc_datapath
  import cusc_pkg::*;
#(
  parameter int MAX_CUS = 32,
  parameter int HOST_W  = 32,
  localparam int CNT_W  = $clog2(MAX_CUS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MAX_CUS-1:0] cuDone,
  input  logic               isrEnable,
  input  logic [CNT_W-1:0]   numCus,
  input  logic [HOST_W-1:0]  hostWrData,
  input  ctrlStrobes_t       strb,
  output logic [MAX_CUS-1:0] cuStatus,
  output logic [HOST_W-1:0]  hostStatus
);
  logic [MAX_CUS-1:0] donePrev;
  logic [MAX_CUS-1:0] inRange;
  logic [MAX_CUS-1:0] setBits;

  // unit i is monitored when its index is below the configured count
  for (genvar i = 0; i < MAX_CUS; i++) begin : g_range
    assign inRange[i] = (numCus > CNT_W'(i));
  end

  assign setBits = isrEnable ? (cuDone & ~donePrev & inRange) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      donePrev <= '0;
      cuStatus <= '0;
    end else begin
      donePrev <= cuDone;
      cuStatus <= (strb.clearCu ? '0 : cuStatus) | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               hostStatus <= '0;
    else if (strb.loadHost)  hostStatus <= hostWrData;
    else if (strb.clearHost) hostStatus <= '0;
  end

  // R6: after a clear, only bits with a fresh qualifying edge remain
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCu |=> (cuStatus & ~$past(setBits)) == '0);
  // R2: pending bits are sticky until a read
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearCu |=> (cuStatus & $past(cuStatus)) == $past(cuStatus));
  // R4: new bits only appear for monitored units
  p_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((cuStatus & ~$past(cuStatus)) & ~$past(inRange)) == '0);
  // R5: capture disabled means no new bits
  p_disabled_r5: assert property (@(posedge clk) disable iff (!rstN)
    !isrEnable |=> (cuStatus & ~$past(cuStatus)) == '0);
  // R8: a processor write is always visible next cycle
  p_hostload_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHost |=> hostStatus == $past(hostWrData));
endmodule

// File: rtl/cu_status_collector.sv
module cu_status_collector
  import cusc_pkg::*;
#(
  parameter int MAX_CUS = 32,
  parameter int HOST_W  = 32,
  localparam int CNT_W  = $clog2(MAX_CUS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MAX_CUS-1:0] cuDone,
  input  logic               isrEnable,
  input  logic [CNT_W-1:0]   numCus,
  input  logic               cpuRd,
  output logic [MAX_CUS-1:0] cuStatus,
  output logic               cpuIrq,
  input  logic               hostIrqEnable,
  input  logic               hostWr,
  input  logic [HOST_W-1:0]  hostWrData,
  input  logic               hostRd,
  output logic [HOST_W-1:0]  hostStatus,
  output logic               hostIrq
);
  ctrlStrobes_t strb;

  cusc_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cpuRd         (cpuRd),
    .hostWr        (hostWr),
    .hostRd        (hostRd),
    .hostIrqEnable (hostIrqEnable),
    .strb          (strb),
    .hostIrq       (hostIrq)
  );

  cusc_datapath #(.MAX_CUS(MAX_CUS), .HOST_W(HOST_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cuDone     (cuDone),
    .isrEnable  (isrEnable),
    .numCus     (numCus),
    .hostWrData (hostWrData),
    .strb       (strb),
    .cuStatus   (cuStatus),
    .hostStatus (hostStatus)
  );

  // R7: processor interrupt follows pending completions
  assign cpuIrq = |cuStatus;
endmodule

// File: tb/sim_cu_status_collector.sv
module sim_cu_status_collector;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int CW = $clog2(N + 1);
  localparam int HW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0]  cuDone = '0;
  logic          isrEnable = 1'b0;
  logic [CW-1:0] numCus = '0;
  logic          cpuRd = 1'b0;
  logic          hostIrqEnable = 1'b0;
  logic          hostWr = 1'b0;
  logic [HW-1:0] hostWrData = '0;
  logic          hostRd = 1'b0;
  logic [N-1:0]  cuStatus;
  logic          cpuIrq;
  logic [HW-1:0] hostStatus;
  logic          hostIrq;

  int compared = 0;
  int mismatched = 0;
  string phaseTag = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cu_status_collector #(.MAX_CUS(N), .HOST_W(HW)) u0 (
    .clk(clk), .rstN(rstN), .cuDone(cuDone), .isrEnable(isrEnable),
    .numCus(numCus), .cpuRd(cpuRd), .cuStatus(cuStatus), .cpuIrq(cpuIrq),
    .hostIrqEnable(hostIrqEnable), .hostWr(hostWr), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostStatus(hostStatus), .hostIrq(hostIrq)
  );

  // Behavioural reference model
  bit [N-1:0]  mCu, mPrev;
  bit [HW-1:0] mHost;
  bit          mHostIrq;

  always @(posedge clk) begin
    bit [N-1:0] nxt;
    if (!rstN) begin
      mCu <= '0; mPrev <= '0; mHost <= '0; mHostIrq <= 0;
    end else begin
      nxt = cpuRd ? '0 : mCu;
      for (int i = 0; i < N; i++)
        if (isrEnable && i < int'(numCus) && cuDone[i] && !mPrev[i]) nxt[i] = 1'b1;
      mCu <= nxt;
      mPrev <= cuDone;
      if (hostWr) mHost <= hostWrData;
      else if (hostRd) mHost <= '0;
      mHostIrq <= hostWr && hostIrqEnable;
    end
  end

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", phaseTag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    cmp("cuStatus", 64'(cuStatus), 64'(mCu));
    cmp("cpuIrq R7", 64'(cpuIrq), 64'(mCu != 0));
    cmp("hostStatus", 64'(hostStatus), 64'(mHost));
    cmp("hostIrq", 64'(hostIrq), 64'(mHostIrq));
  endtask

  // advance one clock, check, leave inputs to be set by caller
  task automatic step();
    @(posedge clk); #1;
    compareAll();
  endtask

  task automatic idle();
    cuDone = '0; cpuRd = 0; hostWr = 0; hostRd = 0;
  endtask

  initial begin
    repeat (3) step();
    phaseTag = "R1";
    rstN = 1'b1;
    step();
    // R1: explicit reset-state check
    cmp("reset state R1", 64'({cuStatus != 0, hostStatus != 0, hostIrq, cpuIrq}), 64'd0);

    // R2: single and multiple rising edges within range
    phaseTag = "R2"; isrEnable = 1; numCus = 8;
    cuDone = 32'h0000_0008; step(); idle(); step();
    cmp("bit3 set R2", 64'(cuStatus), 64'h8);
    cuDone = 32'h0000_0081; step(); idle(); step();
    cmp("bits 0,3,7 R2", 64'(cuStatus), 64'h89);

    // R6: read clears, concurrent completion survives
    phaseTag = "R6"; cpuRd = 1; cuDone = 32'h20; step(); idle(); step();
    cmp("read keeps new bit5 R6", 64'(cuStatus), 64'h20);
    cpuRd = 1; step(); idle(); step();
    cmp("read clears R6", 64'(cuStatus), 64'h0);

    // R3: held level sets once
    phaseTag = "R3"; cuDone = 32'h4;
    step(); step();
    cpuRd = 1; step(); cpuRd = 0; step(); step();
    cmp("held line no reset R3", 64'(cuStatus), 64'h0);
    cuDone = '0; step(); cuDone = 32'h4; step(); idle(); step();
    cmp("re-rise sets R3", 64'(cuStatus), 64'h4);
    cpuRd = 1; step(); idle(); step();

    // R4: out-of-range units, and zero count
    phaseTag = "R4"; cuDone = 32'hFFFF_FF00; step(); idle(); step();
    cmp("out of range R4", 64'(cuStatus), 64'h0);
    numCus = 0; cuDone = 32'h1; step(); idle(); step();
    cmp("zero count R4", 64'(cuStatus), 64'h0);
    numCus = CW'(N); cuDone = 32'h8000_0000; step(); idle(); step();
    cmp("top unit at full count R4", 64'(cuStatus), 64'h8000_0000);
    cpuRd = 1; step(); idle(); step();

    // R5: disabled capture forgets edges
    phaseTag = "R5"; isrEnable = 0; cuDone = 32'h2; step();
    isrEnable = 1; step(); idle(); step();
    cmp("disabled ignored R5", 64'(cuStatus), 64'h0);

    // R8 / R9: host word and pulse
    phaseTag = "R8"; hostWr = 1; hostWrData = 32'hDEAD_BEEF; step(); idle(); step();
    cmp("host load R8", 64'(hostStatus), 64'hDEAD_BEEF);
    cmp("no pulse when disabled R9", 64'(hostIrq), 64'h0);
    hostRd = 1; hostWr = 1; hostWrData = 32'h1234; step(); idle(); step();
    cmp("write wins R8", 64'(hostStatus), 64'h1234);
    hostRd = 1; step(); idle(); step();
    cmp("host clear R8", 64'(hostStatus), 64'h0);
    phaseTag = "R9"; hostIrqEnable = 1;
    hostWr = 1; hostWrData = 32'h5; step(); idle();
    cmp("pulse high R9", 64'(hostIrq), 64'h1);
    step();
    cmp("pulse one cycle R9", 64'(hostIrq), 64'h0);
    hostWr = 1; step(); step(); idle();
    cmp("back-to-back R9", 64'(hostIrq), 64'h1);
    step(); step();

    // mixed random traffic, all requirements against the model
    phaseTag = "R2 R3 R4 R5 R6 R7 R8 R9";
    for (int k = 0; k < 2000; k++) begin
      cuDone = $urandom() & $urandom();
      isrEnable = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 31) == 0) numCus = CW'($urandom_range(0, N));
      cpuRd = ($urandom_range(0, 5) == 0);
      hostIrqEnable = $urandom_range(0, 1);
      hostWr = ($urandom_range(0, 3) == 0);
      hostWrData = $urandom();
      hostRd = ($urandom_range(0, 3) == 0);
      step();
    end
    idle(); step();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule